// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block feeds one transfer channel from a table of descriptors held in memory. Software sets a table pointer and then sets the run bit of a command register. The engine reads the first descriptor over a valid/ready memory read port and shows the resulting address and byte count to the channel. Each descriptor is eight bytes: an address dword, then a count dword whose top bit marks the last entry of the table.

The channel asks for a transfer of a given number of bytes. The engine takes that amount out of the current descriptor and fetches further descriptors as needed. It returns a completion code for every request. A request that stops part-way through a descriptor leaves the advanced address and the reduced count in place, so the next request carries on from that point. A status byte reports whether the engine is running, whether the last entry has been reached, whether the interrupt is enabled, whether an interrupt has occurred, and whether the base and current addresses are non-zero.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset, status_o, ptr_o, cur_addr and cur_count are zero, and busy, mem_req_valid, xfer_done and irq are low.
- R2: A register write with reg_sel=1 updates each byte lane of the table pointer whose reg_be bit is set. ptr_o bits 1:0 always read as zero.
- R3: When not busy, a command write (reg_sel=0, reg_be[0]=1) that changes bit 0 from 0 to 1 raises busy. The engine then issues two memory reads, at the pointer and at pointer+4, and leaves the walk pointer advanced by 8. A request that is not accepted holds its valid and its address.
- R4: The first dword of a descriptor becomes cur_addr, with bit 0 cleared when word_mode=1. The second dword gives cur_count from bits CNT_W-1:0 with bit 0 cleared, and a zero result counts as 2^CNT_W bytes. Bit 31 of the second dword is the last-entry flag.
- R5: Status bits are: 0 running, 7 last entry loaded, 6 interrupt occurred, 5 command bits 7:6 equal 2'b01, 3 base address of the current descriptor non-zero, 2 cur_addr non-zero. Bits 4 and 1 read zero.
- R6: A request shorter than cur_count completes with code 1. cur_addr rises by the length and cur_count falls by the length.
- R7: A request that uses up a descriptor that is not the last one fetches the next descriptor. It completes with code 1 once the request is satisfied, and a request that ends exactly at the boundary leaves the next descriptor loaded.
- R8: A request that ends exactly at the end of the last descriptor completes with code 5 and clears status bit 0.
- R9: A request longer than the bytes left up to the end of the table completes with code 4 and clears status bit 0.
- R10: With command bits 7:6 equal to 2'b01, a completion with code 4 or 5 pulses irq together with xfer_done and sets status bit 6. With any other setting, irq stays low. A start clears bit 6.
- R11: A command write that changes bit 0 from 1 to 0 clears status bits 0 and 7.
- R12: A request made while status bit 0 is clear completes on the next clock with code 2 and issues no memory read.
- R13: A pointer write made while a descriptor fetch is in flight does not change the addresses fetched for the walk in progress. The new value shows on ptr_o and is used at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 selects the table pointer |
| reg_be | input | 4 | Byte lane enables |
| reg_wdata | input | 32 | Write data |
| word_mode | input | 1 | Clear bit 0 of each loaded address |
| status_o | output | 8 | Status byte |
| ptr_o | output | 32 | Programmed table pointer |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | 32 | Memory read address |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| xfer_req | input | 1 | Transfer request, taken while busy is low |
| xfer_len | input | CNT_W+1 | Request length in bytes |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_code | output | 3 | Completion code: 1, 2, 4 or 5 |
| cur_addr | output | 32 | Current transfer address |
| cur_count | output | CNT_W+1 | Bytes left in the current descriptor |
| busy | output | 1 | Fetch or request in progress |
| irq | output | 1 | Interrupt pulse |

## Verification
Two events can coincide: a software write to the table pointer and a descriptor fetch that the hardware is walking. The bench forces this by issuing a request that crosses a descriptor boundary and then writing a new pointer while the memory request of the next fetch is visible. It judges the outcome from the log of memory read addresses, which must continue from the old table. It also checks the completion result and confirms that ptr_o shows the new value. A second overlap is a start write arriving in the same cycle as a request. Start takes priority there, and the assertions on the memory port confirm that a fetch never loses its address while it waits.

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  input  logic             word_mode,
  output logic [7:0]       status_o,
  output logic [31:0]      ptr_o,
  output logic             mem_req_valid,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  input  logic             xfer_req,
  input  logic [CNT_W:0]   xfer_len,
  output logic             xfer_done,
  output logic [2:0]       xfer_code,
  output logic [31:0]      cur_addr,
  output logic [CNT_W:0]   cur_count,
  output logic             busy,
  output logic             irq
);
  localparam int LEN_W = CNT_W + 1;
  localparam logic [LEN_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_AREQ, S_ARSP, S_CREQ, S_CRSP, S_WORK} st_t;
  st_t st;

  logic [7:0]       cmd;
  logic [31:0]      ptr, walk, base, addr;
  logic [LEN_W-1:0] cnt, rem;
  logic             eot, active, int_flag, pend;

  wire cmd_wr = reg_wr && !reg_sel && reg_be[0];
  wire ptr_wr = reg_wr && reg_sel;
  wire go     = cmd_wr && reg_wdata[0] && !cmd[0] && (st == S_IDLE);
  wire halt   = cmd_wr && !reg_wdata[0] && cmd[0];
  wire irq_en = (cmd[7:6] == 2'b01);

  wire [CNT_W-1:0] fld    = {mem_rsp_data[CNT_W-1:1], 1'b0};
  wire [LEN_W-1:0] ld_cnt = (fld == '0) ? FULL : {1'b0, fld};
  wire [31:0]      ld_adr = word_mode ? {mem_rsp_data[31:1], 1'b0} : mem_rsp_data;

  assign ptr_o         = {ptr[31:2], 2'b00};
  assign mem_req_valid = (st == S_AREQ) || (st == S_CREQ);
  assign mem_req_addr  = (st == S_CREQ) ? walk + 32'd4 : walk;
  assign busy          = (st != S_IDLE);
  assign cur_addr      = addr;
  assign cur_count     = cnt;
  assign status_o      = {eot, int_flag, irq_en, 1'b0, base != 32'd0, addr != 32'd0, 1'b0, active};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd <= '0; ptr <= '0; walk <= '0; base <= '0; addr <= '0;
      cnt <= '0; rem <= '0; eot <= 1'b0; active <= 1'b0; int_flag <= 1'b0;
      pend <= 1'b0; xfer_done <= 1'b0; xfer_code <= '0; irq <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      irq       <= 1'b0;
      if (cmd_wr) cmd <= reg_wdata[7:0];
      if (ptr_wr)
        for (int i = 0; i < 4; i++)
          if (reg_be[i]) ptr[8*i +: 8] <= reg_wdata[8*i +: 8];
      if (halt) begin
        active <= 1'b0;
        eot    <= 1'b0;
      end
      case (st)
        S_IDLE: begin
          if (go) begin
            walk     <= ptr_o;
            active   <= 1'b1;
            int_flag <= 1'b0;
            eot      <= 1'b0;
            pend     <= 1'b0;
            st       <= S_AREQ;
          end else if (xfer_req) begin
            if (active) begin
              rem  <= xfer_len;
              pend <= 1'b1;
              st   <= S_WORK;
            end else begin
              xfer_done <= 1'b1;
              xfer_code <= 3'd2;
            end
          end
        end
        S_AREQ: if (mem_req_ready) st <= S_ARSP;
        S_ARSP: if (mem_rsp_valid) begin
          addr <= ld_adr;
          base <= ld_adr;
          st   <= S_CREQ;
        end
        S_CREQ: if (mem_req_ready) st <= S_CRSP;
        S_CRSP: if (mem_rsp_valid) begin
          cnt  <= ld_cnt;
          eot  <= mem_rsp_data[31];
          walk <= walk + 32'd8;
          st   <= pend ? S_WORK : S_IDLE;
        end
        S_WORK: begin
          if (cnt > rem) begin
            addr      <= addr + 32'(rem);
            cnt       <= cnt - rem;
            xfer_done <= 1'b1;
            xfer_code <= 3'd1;
            pend      <= 1'b0;
            st        <= S_IDLE;
          end else begin
            addr <= addr + 32'(cnt);
            cnt  <= '0;
            rem  <= rem - cnt;
            if (eot) begin
              xfer_done <= 1'b1;
              xfer_code <= (rem != cnt) ? 3'd4 : 3'd5;
              active    <= 1'b0;
              pend      <= 1'b0;
              st        <= S_IDLE;
              if (irq_en) begin
                irq      <= 1'b1;
                int_flag <= 1'b1;
              end
            end else begin
              st <= S_AREQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_desc_walker_chk.sv
module sg_desc_walker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       status_o,
  input logic [31:0]      ptr_o,
  input logic             mem_req_valid,
  input logic [31:0]      mem_req_addr,
  input logic             mem_req_ready,
  input logic             xfer_done,
  input logic [2:0]       xfer_code,
  input logic [CNT_W:0]   cur_count,
  input logic             busy,
  input logic             irq
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  a_r3_busy_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r4_count_even: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_count[0]);

  a_r4_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    cur_count <= FULL);

  a_r2_ptr_align: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o[1:0] == 2'b00);

  a_r10_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> xfer_done && (xfer_code == 3'd4 || xfer_code == 3'd5));

  a_r12_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && xfer_code == 3'd2 |-> !$past(status_o[0]));
endmodule

bind sg_desc_walker sg_desc_walker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_o(status_o), .ptr_o(ptr_o),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_req_ready(mem_req_ready), .xfer_done(xfer_done), .xfer_code(xfer_code),
  .cur_count(cur_count), .busy(busy), .irq(irq)
);

// File: tb/tb_sg_desc_walker.sv
`timescale 1ns/1ps
module tb_sg_desc_walker;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, word_mode = 0, xfer_req = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0;
  logic [CNT_W:0] xfer_len = 0;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic [7:0] status_o;
  logic [31:0] ptr_o, mem_req_addr, cur_addr;
  logic mem_req_valid, xfer_done, busy, irq;
  logic [2:0] xfer_code;
  logic [CNT_W:0] cur_count;

  logic [31:0] mem [64];
  logic [31:0] flog [32];
  int nlog = 0;
  int errors = 0, checks = 0;
  logic [2:0] got_code;
  logic got_irq;

  always #2.5 clk = ~clk;

  sg_desc_walker #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .word_mode(word_mode), .status_o(status_o), .ptr_o(ptr_o),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .xfer_req(xfer_req), .xfer_len(xfer_len),
    .xfer_done(xfer_done), .xfer_code(xfer_code), .cur_addr(cur_addr),
    .cur_count(cur_count), .busy(busy), .irq(irq)
  );

  always @(posedge clk) begin
    mem_req_ready <= ~mem_req_ready;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[7:2]];
    if (mem_req_valid && mem_req_ready) begin
      flog[nlog[4:0]] <= mem_req_addr;
      nlog <= nlog + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic request(input int len);
    @(negedge clk);
    xfer_req = 1; xfer_len = len[CNT_W:0];
    @(negedge clk);
    xfer_req = 0;
    for (int i = 0; i < 200 && !xfer_done; i++) @(negedge clk);
    got_code = xfer_code;
    got_irq  = irq;
    check("R1 done seen", {31'd0, xfer_done}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 status", {24'd0, status_o}, 32'd0);
    check("R1 ptr", ptr_o, 32'd0);
    check("R1 addr", cur_addr, 32'd0);
    check("R1 count", {15'd0, cur_count}, 32'd0);
    check("R1 outputs", {28'd0, busy, mem_req_valid, xfer_done, irq}, 32'd0);
  endtask

  task automatic t_pointer();
    wr(1, 4'b0001, 32'h1234_56FF);
    check("R2 byte lane", ptr_o, 32'h0000_00FC);
    wr(1, 4'b0110, 32'h77AB_CD00);
    check("R2 word lanes", ptr_o, 32'h00AB_CDFC);
    wr(1, 4'b1111, 32'h0000_0043);
    check("R2 dword align", ptr_o, 32'h0000_0040);
  endtask

  task automatic t_inactive();
    int n0 = nlog;
    request(4);
    check("R12 code", {29'd0, got_code}, 32'd2);
    check("R12 no fetch", nlog - n0, 0);
  endtask

  task automatic t_start();
    int n0 = nlog;
    word_mode = 0;
    wr(0, 4'b0001, 32'h41);
    check("R3 busy", {31'd0, busy}, 32'd1);
    wait_idle();
    check("R3 two reads", nlog - n0, 2);
    check("R3 read addr", flog[n0], 32'h40);
    check("R3 read count", flog[n0+1], 32'h44);
    check("R4 addr", cur_addr, 32'h1000);
    check("R4 count even", {15'd0, cur_count}, 32'h10);
    check("R5 status", {24'd0, status_o}, 32'h2D);
  endtask

  task automatic t_partial();
    request(6);
    check("R6 code", {29'd0, got_code}, 32'd1);
    check("R6 addr", cur_addr, 32'h1006);
    check("R6 count", {15'd0, cur_count}, 32'h0A);
  endtask

  task automatic t_boundary();
    int n0 = nlog;
    word_mode = 1;
    request(10);
    check("R7 code", {29'd0, got_code}, 32'd1);
    check("R7 next fetch", flog[n0], 32'h48);
    check("R3 walk step", flog[n0+1], 32'h4C);
    check("R4 word addr", cur_addr, 32'h2000);
    check("R4 zero count", {15'd0, cur_count}, 32'h10000);
    check("R5 last flag", {24'd0, status_o}, 32'hAD);
  endtask

  task automatic t_end();
    request(32'h10000);
    check("R8 code", {29'd0, got_code}, 32'd5);
    check("R10 irq", {31'd0, got_irq}, 32'd1);
    check("R8 R10 status", {24'd0, status_o}, 32'hEC);
    check("R8 addr", cur_addr, 32'h12000);
  endtask

  task automatic t_stop();
    wr(0, 4'b0001, 32'h40);
    check("R11 status", {24'd0, status_o}, 32'h6C);
  endtask

  task automatic t_overrun();
    word_mode = 0;
    wr(1, 4'b1111, 32'h80);
    wr(0, 4'b0001, 32'h01);
    wait_idle();
    check("R10 start clears", {31'd0, status_o[6]}, 32'd0);
    request(10);
    check("R9 code", {29'd0, got_code}, 32'd4);
    check("R10 no irq", {31'd0, got_irq}, 32'd0);
    check("R9 status", {24'd0, status_o}, 32'h8C);
    check("R9 addr", cur_addr, 32'h3004);
  endtask

  task automatic t_collide();
    int n0;
    wr(0, 4'b0001, 32'h00);
    wr(1, 4'b1111, 32'hC0);
    wr(0, 4'b0001, 32'h01);
    wait_idle();
    check("R4 first", cur_addr, 32'h4000);
    n0 = nlog;
    @(negedge clk);
    xfer_req = 1; xfer_len = 2;
    @(negedge clk);
    xfer_req = 0;
    for (int i = 0; i < 50 && !mem_req_valid; i++) @(negedge clk);
    reg_wr = 1; reg_sel = 1; reg_be = 4'hF; reg_wdata = 32'h100;
    @(negedge clk);
    reg_wr = 0;
    for (int i = 0; i < 200 && !xfer_done; i++) @(negedge clk);
    check("R13 code", {29'd0, xfer_code}, 32'd1);
    check("R13 fetch addr", flog[n0], 32'hC8);
    check("R13 fetch count", flog[n0+1], 32'hCC);
    check("R13 walk addr", cur_addr, 32'h5000);
    check("R13 new ptr", ptr_o, 32'h100);
    request(8);
    check("R13 R8 finish", {29'd0, got_code}, 32'd5);
    check("R13 count", {15'd0, cur_count}, 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[16] = 32'h0000_1000; mem[17] = 32'h0000_0011;
    mem[18] = 32'h0000_2001; mem[19] = 32'h8000_0000;
    mem[32] = 32'h0000_3000; mem[33] = 32'h8000_0004;
    mem[48] = 32'h0000_4000; mem[49] = 32'h0000_0002;
    mem[50] = 32'h0000_5000; mem[51] = 32'h8000_0008;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_inactive();
    t_start();
    t_partial();
    t_boundary();
    t_end();
    t_stop();
    t_overrun();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule